// File: doc/BRIEF.md
# Calendar Timekeeper with Transactional Access

This block holds a full calendar time as eight BCD bytes: seconds, minutes, hours, month, date, two-digit year, day of week and century. A 1 Hz enable input moves the time forward by one second, and every carry as far as the century is resolved in the same clock cycle. The calendar handles short months and leap years up to the end of 2099. The hours byte can hold either a 24-hour value or a 12-hour value with an AM/PM flag.

A serial-bus slave front end reaches the eight bytes through a set of byte-level strobes. The address acknowledge opens a transaction and gives its direction and a start index. Each data acknowledge moves one byte. A valid stop or an abort closes the transaction. When a read opens, the running time is frozen into a snapshot, so a multi-byte read always returns one consistent time while counting goes on. Written bytes are held in a staging buffer. They reach the live counters only when a valid stop closes the write; an abort drops them. At reset the block stands for a clock that has lost all power, and it does not count until the first committed write. Every commit sends a one-cycle pulse to the external divider so that the sub-second phase starts again from that point.

Top module: `rtc_timekeeper`

## Requirements
- R1: Byte index 0..7 holds seconds, minutes, hours, month, date, year, day of week and century, all BCD. After reset these read 00, 00, 80, 01, 01, 00, 00, 20 and both `rd_data` and `div_restart` are 0.
- R2: From reset until the first committed write, `tick_1hz` pulses leave the time unchanged.
- R3: In 24-hour mode (hours bit 7 = 1, BCD 00-23 in bits 5:0), seconds wrap 59 to 00 and carry into minutes, minutes carry into hours, and hour 23 wraps to 00 and advances the date, all on a single tick.
- R4: The date wraps to 01 and the month advances after day 30 in April, June, September and November, and after day 31 in the other non-February months.
- R5: February ends at day 29 when the BCD year is a multiple of 4 (including 00) and at day 28 otherwise.
- R6: Month 12 wraps to 01 and advances the year; year 99 wraps to 00 and increments the BCD century byte.
- R7: Day of week counts 0 to 6, wraps to 0, and advances on every date change.
- R8: In 12-hour mode (hours bit 7 = 0, bit 5 = PM, BCD 01-12 in bits 4:0), 11 goes to 12 and toggles PM, 12 goes to 01 with PM unchanged, and 11 PM going to 12 AM advances the date.
- R9: An address acknowledge with read direction copies the live time into a snapshot. Every byte of that read returns the snapshot, even when ticks occur during the read.
- R10: The live time keeps counting while a write is being staged. At commit, bytes that were not written keep their running values.
- R11: An abort discards all staged bytes. The live time is unchanged and no divider restart is issued.
- R12: A valid stop ending a write that carried at least one byte copies the staged bytes into the live time and pulses `div_restart` for one cycle, in the cycle after the stop. A stop ending a read does neither.
- R13: The byte pointer starts at `adr_idx`, advances on each data acknowledge and wraps from 7 to 0. `rd_data` shows the snapshot byte at the pointer one cycle after the pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-second advance enable, one cycle wide |
| adr_ack | input | 1 | Address phase acknowledged; opens a transaction |
| adr_rd | input | 1 | Direction qualifier for `adr_ack` (1 = read) |
| adr_idx | input | 3 | Start byte index for the transaction |
| dat_ack | input | 1 | Data byte acknowledged |
| wr_data | input | 8 | Write byte, sampled with `dat_ack` |
| bus_stop | input | 1 | Valid stop ends the transaction |
| bus_abort | input | 1 | Invalid sequence; transaction dropped |
| rd_data | output | 8 | Snapshot byte at the current pointer |
| div_restart | output | 1 | One-cycle pulse after a commit, for the sub-second divider |

## Verification
The assertions check the invariants that hold on every cycle. The live time never moves without a tick or a commit, and it stays frozen while the block is halted. The snapshot changes only when a read opens. An abort empties the staging mask. Each commit is followed by a restart pulse with the block out of the halted state, and a tick on second 59 always gives 00. Only the bench scenarios can show the calendar values themselves: month ends, leap and non-leap Februaries, the century carry and the 12-hour AM/PM sequence. The same holds for the values returned across a read with ticks in the middle, partial commits that meet running bytes, and pointer wrap-around.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int NREG  = 8;
  localparam int IDX_W = $clog2(NREG);

  localparam int IX_SEC  = 0;
  localparam int IX_MIN  = 1;
  localparam int IX_HR   = 2;
  localparam int IX_MON  = 3;
  localparam int IX_DATE = 4;
  localparam int IX_YR   = 5;
  localparam int IX_DOW  = 6;
  localparam int IX_CEN  = 7;

  localparam int HR_24 = 7;
  localparam int HR_PM = 5;

  typedef logic [NREG-1:0][7:0] tfile_t;

  // century, dow, year, date, month, hours(24h 00), minutes, seconds
  localparam tfile_t TIME_RST = {8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h80, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by 4: odd tens need units 2/6, even tens need 0/4/8
  function automatic logic leap_yr(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_yr(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_step.sv
`timescale 1ns/1ps
module rtc_cal_step
  import rtc_pkg::*;
(
  input  tfile_t cur,
  output tfile_t nxt
);
  logic c_min, c_hr, c_day, c_mon, c_yr, c_cen;

  always_comb begin
    nxt   = cur;
    c_min = 1'b0;
    c_hr  = 1'b0;
    c_day = 1'b0;
    c_mon = 1'b0;
    c_yr  = 1'b0;
    c_cen = 1'b0;

    if (cur[IX_SEC] >= 8'h59) begin
      nxt[IX_SEC] = 8'h00;
      c_min = 1'b1;
    end else nxt[IX_SEC] = bcd_inc(cur[IX_SEC]);

    if (c_min) begin
      if (cur[IX_MIN] >= 8'h59) begin
        nxt[IX_MIN] = 8'h00;
        c_hr = 1'b1;
      end else nxt[IX_MIN] = bcd_inc(cur[IX_MIN]);
    end

    if (c_hr) begin
      if (cur[IX_HR][HR_24]) begin
        if (cur[IX_HR][5:0] >= 6'h23) begin
          nxt[IX_HR] = 8'h80;
          c_day = 1'b1;
        end else nxt[IX_HR] = bcd_inc({2'b00, cur[IX_HR][5:0]}) | 8'h80;
      end else begin
        if (cur[IX_HR][4:0] >= 5'h12) begin
          nxt[IX_HR] = {2'b00, cur[IX_HR][HR_PM], 5'h01};
        end else if (cur[IX_HR][4:0] == 5'h11) begin
          nxt[IX_HR] = {2'b00, ~cur[IX_HR][HR_PM], 5'h12};
          c_day = cur[IX_HR][HR_PM];
        end else begin
          nxt[IX_HR] = bcd_inc({3'b000, cur[IX_HR][4:0]}) | {2'b00, cur[IX_HR][HR_PM], 5'b0};
        end
      end
    end

    if (c_day) begin
      nxt[IX_DOW] = (cur[IX_DOW] >= 8'h06) ? 8'h00 : cur[IX_DOW] + 8'h01;
      if (cur[IX_DATE] >= last_day(cur[IX_MON], cur[IX_YR])) begin
        nxt[IX_DATE] = 8'h01;
        c_mon = 1'b1;
      end else nxt[IX_DATE] = bcd_inc(cur[IX_DATE]);
    end

    if (c_mon) begin
      if (cur[IX_MON] >= 8'h12) begin
        nxt[IX_MON] = 8'h01;
        c_yr = 1'b1;
      end else nxt[IX_MON] = bcd_inc(cur[IX_MON]);
    end

    if (c_yr) begin
      if (cur[IX_YR] >= 8'h99) begin
        nxt[IX_YR] = 8'h00;
        c_cen = 1'b1;
      end else nxt[IX_YR] = bcd_inc(cur[IX_YR]);
    end

    if (c_cen) nxt[IX_CEN] = bcd_inc(cur[IX_CEN]);
  end
endmodule

// File: rtl/rtc_bus_port.sv
`timescale 1ns/1ps
module rtc_bus_port
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             adr_ack,
  input  logic             adr_rd,
  input  logic [IDX_W-1:0] adr_idx,
  input  logic             dat_ack,
  input  logic [7:0]       wr_data,
  input  logic             bus_stop,
  input  logic             bus_abort,
  input  tfile_t           live,
  output logic [7:0]       rd_data,
  output tfile_t           stage,
  output logic [NREG-1:0]  stage_mask,
  output logic             commit
);
  logic             act, rd_mode;
  logic [IDX_W-1:0] ptr;
  tfile_t           snap;

  assign commit = bus_stop && act && !rd_mode && (|stage_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      act        <= 1'b0;
      rd_mode    <= 1'b0;
      ptr        <= '0;
      snap       <= '0;
      stage      <= '0;
      stage_mask <= '0;
      rd_data    <= '0;
    end else begin
      rd_data <= snap[ptr];
      if (bus_abort || bus_stop) begin
        act        <= 1'b0;
        stage_mask <= '0;
      end else if (adr_ack) begin
        act        <= 1'b1;
        rd_mode    <= adr_rd;
        ptr        <= adr_idx;
        stage_mask <= '0;
        if (adr_rd) snap <= live;
      end else if (dat_ack && act) begin
        ptr <= ptr + 1'b1;
        if (!rd_mode) begin
          stage[ptr]      <= wr_data;
          stage_mask[ptr] <= 1'b1;
        end
      end
    end
  end

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(adr_ack && adr_rd) |=> $stable(snap));

  // R11
  abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
    bus_abort |=> (stage_mask == '0));
endmodule

// File: rtl/rtc_timekeeper.sv
`timescale 1ns/1ps
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_1hz,
  input  logic             adr_ack,
  input  logic             adr_rd,
  input  logic [IDX_W-1:0] adr_idx,
  input  logic             dat_ack,
  input  logic [7:0]       wr_data,
  input  logic             bus_stop,
  input  logic             bus_abort,
  output logic [7:0]       rd_data,
  output logic             div_restart
);
  tfile_t          live, nxt, stage;
  logic [NREG-1:0] stage_mask;
  logic            commit, halted;

  rtc_cal_step u_step (.cur(live), .nxt(nxt));

  rtc_bus_port u_port (
    .clk(clk), .rst(rst),
    .adr_ack(adr_ack), .adr_rd(adr_rd), .adr_idx(adr_idx),
    .dat_ack(dat_ack), .wr_data(wr_data),
    .bus_stop(bus_stop), .bus_abort(bus_abort),
    .live(live), .rd_data(rd_data),
    .stage(stage), .stage_mask(stage_mask), .commit(commit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      live        <= TIME_RST;
      halted      <= 1'b1;
      div_restart <= 1'b0;
    end else begin
      div_restart <= commit;
      if (commit) begin
        halted <= 1'b0;
        for (int i = 0; i < NREG; i++)
          if (stage_mask[i]) live[i] <= stage[i];
      end else if (tick_1hz && !halted) begin
        live <= nxt;
      end
    end
  end

  // R2
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && !commit) |=> $stable(live));

  // R10
  live_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!commit && !tick_1hz) |=> $stable(live));

  // R12
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (div_restart && !halted));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_1hz && !halted && !commit && live[IX_SEC] == 8'h59) |=> (live[IX_SEC] == 8'h00));
endmodule

// File: tb/rtc_timekeeper_tb_top.sv
`timescale 1ns/1ps
module rtc_timekeeper_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0, adr_ack = 1'b0, adr_rd = 1'b0, dat_ack = 1'b0;
  logic [2:0] adr_idx = '0;
  logic [7:0] wr_data = '0;
  logic       bus_stop = 1'b0, bus_abort = 1'b0;
  logic [7:0] rd_data;
  logic       div_restart;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic smp = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_timekeeper dut_i (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz),
    .adr_ack(adr_ack), .adr_rd(adr_rd), .adr_idx(adr_idx),
    .dat_ack(dat_ack), .wr_data(wr_data),
    .bus_stop(bus_stop), .bus_abort(bus_abort),
    .rd_data(rd_data), .div_restart(div_restart)
  );

  function automatic logic [63:0] mk(input logic [7:0] s, mi, h, mo, d, y, w, c);
    return {c, w, y, d, mo, h, mi, s};
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string tag, input logic [7:0] got, input logic [7:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, expv);
    end
  endtask

  // monitor: pops the scoreboard when the driver marks a valid read byte
  always @(negedge clk) begin
    if (smp) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty got=%h exp=none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s got=%h exp=%h", t, rd_data, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1hz = 1'b1; cyc(); tick_1hz = 1'b0; cyc();
    end
  endtask

  task automatic wr_page(input logic [2:0] idx, input int n, input logic [63:0] v,
                         input bit do_abort, input int tk_n);
    cyc(); adr_ack = 1'b1; adr_rd = 1'b0; adr_idx = idx;
    cyc(); adr_ack = 1'b0;
    for (int k = 0; k < n; k++) begin
      int j;
      j = (int'(idx) + k) % 8;
      dat_ack = 1'b1; wr_data = v[8*j +: 8];
      cyc(); dat_ack = 1'b0;
    end
    for (int k = 0; k < tk_n; k++) begin
      tick_1hz = 1'b1; cyc(); tick_1hz = 1'b0;
    end
    if (do_abort) bus_abort = 1'b1; else bus_stop = 1'b1;
    cyc(); bus_abort = 1'b0; bus_stop = 1'b0;
  endtask

  task automatic rd_page(input logic [2:0] idx, input int n, input logic [63:0] v,
                         input bit tk, input string tag);
    cyc(); adr_ack = 1'b1; adr_rd = 1'b1; adr_idx = idx;
    cyc(); adr_ack = 1'b0;
    for (int k = 0; k < n; k++) begin
      int j;
      j = (int'(idx) + k) % 8;
      if (k > 0) begin
        dat_ack = 1'b1; tick_1hz = tk;
        cyc(); dat_ack = 1'b0; tick_1hz = 1'b0;
      end
      cyc();
      exp_q.push_back(v[8*j +: 8]);
      tag_q.push_back($sformatf("%s byte%0d", tag, j));
      smp = 1'b1;
      cyc(); smp = 1'b0;
    end
    bus_stop = 1'b1; cyc(); bus_stop = 1'b0;
  endtask

  task automatic commit_pulse(input string tag);
    @(negedge clk);
    check(div_restart === 1'b1, tag, {7'd0, div_restart}, 8'h01);
    @(negedge clk);
    check(div_restart === 1'b0, tag, {7'd0, div_restart}, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got=hang exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    @(negedge clk);
    // R1 reset outputs
    check(rd_data === 8'h00, "R1 rd_data", rd_data, 8'h00);
    check(div_restart === 1'b0, "R1 div_restart", {7'd0, div_restart}, 8'h00);
    rd_page(0, 8, mk(8'h00,8'h00,8'h80,8'h01,8'h01,8'h00,8'h00,8'h20), 1'b0, "R1 reset");

    // R2 halted until first write
    tick(3);
    rd_page(0, 8, mk(8'h00,8'h00,8'h80,8'h01,8'h01,8'h00,8'h00,8'h20), 1'b0, "R2 halted");

    // R12 commit and restart pulse; R3 R6 R7 full carry chain
    wr_page(0, 8, mk(8'h55,8'h59,8'hA3,8'h12,8'h31,8'h99,8'h06,8'h20), 1'b0, 0);
    commit_pulse("R12 restart");
    rd_page(0, 8, mk(8'h55,8'h59,8'hA3,8'h12,8'h31,8'h99,8'h06,8'h20), 1'b0, "R12 readback");
    @(negedge clk);
    check(div_restart === 1'b0, "R12 read stop", {7'd0, div_restart}, 8'h00);
    tick(5);
    rd_page(0, 8, mk(8'h00,8'h00,8'h80,8'h01,8'h01,8'h00,8'h00,8'h21), 1'b0, "R3 R6 R7 rollover");

    // R4 month lengths
    wr_page(0, 8, mk(8'h59,8'h59,8'hA3,8'h04,8'h30,8'h23,8'h02,8'h20), 1'b0, 0);
    tick(1);
    rd_page(0, 8, mk(8'h00,8'h00,8'h80,8'h05,8'h01,8'h23,8'h03,8'h20), 1'b0, "R4 april");
    wr_page(0, 8, mk(8'h59,8'h59,8'hA3,8'h01,8'h31,8'h24,8'h05,8'h20), 1'b0, 0);
    tick(1);
    rd_page(0, 8, mk(8'h00,8'h00,8'h80,8'h02,8'h01,8'h24,8'h06,8'h20), 1'b0, "R4 january");

    // R5 leap handling
    wr_page(0, 8, mk(8'h59,8'h59,8'hA3,8'h02,8'h28,8'h24,8'h01,8'h20), 1'b0, 0);
    tick(1);
    rd_page(0, 8, mk(8'h00,8'h00,8'h80,8'h02,8'h29,8'h24,8'h02,8'h20), 1'b0, "R5 leap 28");
    wr_page(0, 8, mk(8'h59,8'h59,8'hA3,8'h02,8'h29,8'h24,8'h03,8'h20), 1'b0, 0);
    tick(1);
    rd_page(0, 8, mk(8'h00,8'h00,8'h80,8'h03,8'h01,8'h24,8'h04,8'h20), 1'b0, "R5 leap 29");
    wr_page(0, 8, mk(8'h59,8'h59,8'hA3,8'h02,8'h28,8'h23,8'h06,8'h20), 1'b0, 0);
    tick(1);
    rd_page(0, 8, mk(8'h00,8'h00,8'h80,8'h03,8'h01,8'h23,8'h00,8'h20), 1'b0, "R5 common");
    wr_page(0, 8, mk(8'h59,8'h59,8'hA3,8'h02,8'h28,8'h00,8'h01,8'h20), 1'b0, 0);
    tick(1);
    rd_page(0, 8, mk(8'h00,8'h00,8'h80,8'h02,8'h29,8'h00,8'h02,8'h20), 1'b0, "R5 year00");

    // R8 12-hour mode
    wr_page(0, 8, mk(8'h59,8'h59,8'h11,8'h06,8'h10,8'h25,8'h01,8'h20), 1'b0, 0);
    tick(1);
    rd_page(0, 8, mk(8'h00,8'h00,8'h32,8'h06,8'h10,8'h25,8'h01,8'h20), 1'b0, "R8 noon");
    wr_page(0, 8, mk(8'h59,8'h59,8'h32,8'h06,8'h10,8'h25,8'h01,8'h20), 1'b0, 0);
    tick(1);
    rd_page(0, 8, mk(8'h00,8'h00,8'h21,8'h06,8'h10,8'h25,8'h01,8'h20), 1'b0, "R8 1pm");
    wr_page(0, 8, mk(8'h59,8'h59,8'h31,8'h06,8'h10,8'h25,8'h01,8'h20), 1'b0, 0);
    tick(1);
    rd_page(0, 8, mk(8'h00,8'h00,8'h12,8'h06,8'h11,8'h25,8'h02,8'h20), 1'b0, "R8 midnight");

    // R9 snapshot holds while ticks arrive mid-read
    wr_page(0, 8, mk(8'h10,8'h00,8'h80,8'h07,8'h04,8'h25,8'h05,8'h20), 1'b0, 0);
    rd_page(0, 8, mk(8'h10,8'h00,8'h80,8'h07,8'h04,8'h25,8'h05,8'h20), 1'b1, "R9 frozen");
    rd_page(0, 8, mk(8'h17,8'h00,8'h80,8'h07,8'h04,8'h25,8'h05,8'h20), 1'b0, "R9 advanced");

    // R13 start index and wrap
    rd_page(6, 3, mk(8'h17,8'h00,8'h80,8'h07,8'h04,8'h25,8'h05,8'h20), 1'b0, "R13 wrap");

    // R11 abort discards
    wr_page(0, 8, mk(8'h00,8'h11,8'h82,8'h03,8'h03,8'h30,8'h01,8'h20), 1'b1, 0);
    @(negedge clk);
    check(div_restart === 1'b0, "R11 no restart", {7'd0, div_restart}, 8'h00);
    rd_page(0, 8, mk(8'h17,8'h00,8'h80,8'h07,8'h04,8'h25,8'h05,8'h20), 1'b0, "R11 unchanged");

    // R10 partial write while counting continues
    wr_page(1, 1, mk(8'h00,8'h30,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00), 1'b0, 2);
    commit_pulse("R12 partial restart");
    rd_page(0, 8, mk(8'h19,8'h30,8'h80,8'h07,8'h04,8'h25,8'h05,8'h20), 1'b0, "R10 partial");

    repeat (4) cyc();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule